// File: doc/BRIEF.md
# Packed Four-Pixel Byte Averager

This block filters packed pixel data. Two 64-bit operands arrive together, each holding eight unsigned bytes: operand A is one row of pixels and operand B is the row below it. For every pair of horizontally adjacent lanes, the block adds the 2×2 square of four pixels, adds a small rounding constant and divides by four. The result is one averaged byte per lane. This is the half-pixel interpolation step used in motion compensation. The highest output lane has no right-hand neighbour, so it is forced to zero and never wraps around to lane 0.

The datapath is a single adder tree per lane followed by one output register. A valid strobe qualifies the operands. The result and a matching valid flag appear on the clock edge after the strobe. While the strobe is low, the previous result is held. A mode input selects the rounding constant: 1 in the plain mode and 2 in the rounding mode.

Top module: `quad_byte_avg`

## Requirements
- R1: Lane k of each operand and of the result occupies bits [8k+7:8k], and input lanes are treated as unsigned 8-bit values.
- R2: For k from 0 to 6, result lane k equals (A[k] + A[k+1] + B[k] + B[k+1] + C) divided by 4, rounding down, where C is the rounding constant.
- R3: C is 1 when `round_mode` is 0 and 2 when `round_mode` is 1.
- R4: Result lane 7 is always zero. Input lane 7 contributes only to result lane 6, and input lane 0 is never combined with input lane 7.
- R5: The lane sum never overflows. With every input byte at 255, each of result lanes 0 to 6 is 255 in both modes, without saturation logic.
- R6: When `in_valid` is high at a clock edge, the result for the operands sampled at that edge is visible on `out_data` after that edge, and `out_valid` equals the value of `in_valid` at the previous edge.
- R7: While `in_valid` is low, changes on `op_a`, `op_b` and `round_mode` leave `out_data` unchanged.
- R8: While `rst_n` is low at a clock edge, `out_data` and `out_valid` are cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the operands and the mode |
| round_mode | input | 1 | 0 selects rounding constant 1, 1 selects 2 |
| op_a | input | 64 | Upper pixel row, eight unsigned bytes |
| op_b | input | 64 | Lower pixel row, eight unsigned bytes |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_data | output | 64 | Eight averaged bytes; lane 7 always zero |

## Verification
The hardest cases to reach are the ones where the rounding constant is the only thing that moves a lane's result across a multiple of four. In these cases the two modes give different results only for particular residues of the four-byte sum. To cover every residue at every lane, the stimulus sweeps one byte value through all 256 codes, pairs it with sixteen spread values of a second byte, and derives the other lanes from lane-dependent offsets. The sweep runs in both modes. Separate directed vectors isolate lane 7 of the inputs to show that its effect stops at result lane 6. Another set drives all-ones to reach the largest possible sum.

// File: rtl/quad_byte_avg.sv
module quad_byte_avg #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    round_mode,
  input  logic [LANES*LANE_W-1:0] op_a,
  input  logic [LANES*LANE_W-1:0] op_b,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int SUM_W  = LANE_W + 3;

  logic [SUM_W-1:0]  rnd;
  logic [DATA_W-1:0] avg;

  assign rnd = {{(SUM_W-2){1'b0}}, round_mode, ~round_mode};

  for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(op_a[k*LANE_W +: LANE_W])
               + SUM_W'(op_a[(k+1)*LANE_W +: LANE_W])
               + SUM_W'(op_b[k*LANE_W +: LANE_W])
               + SUM_W'(op_b[(k+1)*LANE_W +: LANE_W])
               + rnd;
    assign avg[k*LANE_W +: LANE_W] = sum[LANE_W+1:2];
  end

  assign avg[DATA_W-1 -: LANE_W] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= avg;
    end
  end
endmodule

// File: rtl/quad_byte_avg_chk.sv
module quad_byte_avg_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    round_mode,
  input logic [LANES*LANE_W-1:0] op_a,
  input logic [LANES*LANE_W-1:0] op_b,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] out_data
);
  localparam int W = LANE_W + 3;

  logic [W-1:0] low_sum;
  assign low_sum = W'(op_a[LANE_W-1:0]) + W'(op_b[LANE_W-1:0])
                 + W'(op_a[2*LANE_W-1:LANE_W]) + W'(op_b[2*LANE_W-1:LANE_W])
                 + (round_mode ? W'(2) : W'(1));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R4
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_data[LANES*LANE_W-1 -: LANE_W] == '0);

  // R2
  low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[LANE_W-1:0] == $past(low_sum[LANE_W+1:2]));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));
endmodule

bind quad_byte_avg quad_byte_avg_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .round_mode(round_mode),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/quad_byte_avg_test.sv
module quad_byte_avg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        round_mode = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] out_data;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  quad_byte_avg uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .round_mode(round_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic m);
    logic [63:0] r = '0;
    for (int k = 0; k < 7; k++) begin
      int s = int'(a[8*k +: 8]) + int'(a[8*(k+1) +: 8])
            + int'(b[8*k +: 8]) + int'(b[8*(k+1) +: 8]) + (m ? 2 : 1);
      r[8*k +: 8] = 8'((s / 4) % 256);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic m);
    @(negedge clk);
    op_a = a; op_b = b; round_mode = m; in_valid = 1'b1;
    @(negedge clk);
    check(tag, {out_valid, out_data}, {1'b1, model(a, b, m)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset", {out_valid, out_data}, 65'd0);
    rst_n = 1'b1;

    // R4 lane 7 only reaches lane 6, lane 0 not wrapped
    apply("R4 top lanes", 64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0000, 1'b0);
    check("R4 lane6", {57'd0, out_data[55:48]}, 65'd127);
    check("R4 lane0", {57'd0, out_data[7:0]}, 65'd0);
    apply("R4 low lane", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00FF, 1'b1);
    check("R4 no wrap", {57'd0, out_data[63:56]}, 65'd0);

    // R5 largest sum in both modes
    apply("R5 max plain", '1, '1, 1'b0);
    check("R5 value", {1'b0, out_data}, {1'b0, 64'h00FF_FFFF_FFFF_FFFF});
    apply("R5 max round", '1, '1, 1'b1);

    // R3 rounding constant: sum 2 -> 0 in plain, 1 in rounding
    apply("R3 plain", 64'h0000_0000_0000_0101, 64'h0, 1'b0);
    check("R3 plain lane0", {57'd0, out_data[7:0]}, 65'd0);
    apply("R3 round", 64'h0000_0000_0000_0101, 64'h0, 1'b1);
    check("R3 round lane0", {57'd0, out_data[7:0]}, 65'd1);

    // R1 R2 R3 sweep
    for (int m = 0; m < 2; m++)
      for (int y = 0; y < 256; y += 17)
        for (int x = 0; x < 256; x++) begin
          logic [63:0] a, b;
          for (int k = 0; k < 8; k++) begin
            a[8*k +: 8] = 8'(x ^ (k * 37));
            b[8*k +: 8] = 8'(y + k * 11 + x * k);
          end
          apply(m ? "R2 R3 sweep round" : "R1 R2 sweep plain", a, b, m[0]);
        end

    // R7 hold while invalid; R6 valid drops
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0; op_a = 64'h0123_4567_89AB_CDEF; op_b = ~op_a; round_mode = ~round_mode;
    @(negedge clk);
    check("R6 valid low", {64'd0, out_valid}, 65'd0);
    op_a = '1; op_b = '1;
    @(negedge clk);
    check("R7 hold", {1'b0, out_data}, {1'b0, held});

    // R6 single-cycle latency
    apply("R6 latency", 64'h1020_3040_5060_7080, 64'h0807_0605_0403_0201, 1'b0);

    // R8 mid-run reset
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R8 mid reset", {out_valid, out_data}, 65'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule